// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire PHY management bus (MDC clock, MDIO data) on behalf of software. Software first programs a clock divider, then writes one 32-bit word that already holds a complete management frame: start pattern, opcode, PHY address, register address, turnaround and 16 data bits. The block sends 32 preamble ones and then the word, most significant bit first. On a read it releases MDIO for the second half of the frame and collects the 16 bits the PHY returns into the low half of the same data register. When the frame ends it sets a completion event bit, which software clears by writing a one to it.

The sequencer has four states. IDLE holds MDC low and MDIO released. A command accepted in IDLE moves it to PREAMBLE. After the 32nd preamble bit, the falling MDC edge moves it to FRAME. After the last frame bit, the falling MDC edge moves it to FINISH. FINISH lasts one clock: it stores the read data, sets the event and returns to IDLE. MDIO changes only on falling MDC edges. Read data is sampled on rising MDC edges.

The register file has three word slots, chosen by a 2-bit index: 0 is command/data, 1 is speed and 2 is event. The speed register keeps its value in bits 6:1. Bit 0 always reads 0. MDC runs at the system clock divided by twice the speed register value. This means each MDC half period lasts as many system clocks as the register value (always even). A value of 0 stops the bus.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset MDC is low, MDIO is released (`mdio_oe` = 0) and all three registers read 0.
- R2: A write to index 0 accepted in IDLE produces 32 driven ones on MDIO, followed by the 32 written bits, bit 31 first.
- R3: Each MDC half period lasts exactly the speed register value in system clocks. The speed register stores write bits 6:1 and reads bit 0 as 0. MDC is low whenever no frame is running.
- R4: MDIO output and output enable change only when MDC falls or while MDC is low. They never change while MDC stays high.
- R5: A frame whose bits 29:28 are 10 is a read. MDIO is released from frame bit 16 (the second turnaround bit) to the end of the frame. The 16 bits sampled on the rising MDC edges of frame bits 15..0 replace data register bits 15:0, first sample in bit 15. Bits 31:16 keep the command.
- R6: Any other opcode value drives MDIO for the whole frame and leaves the data register unchanged.
- R7: One clock after the final falling MDC edge, event bit 23 (index 2) becomes 1. It is set at no other time.
- R8: Writing index 2 with bit 23 = 1 clears the event. Writing it with bit 23 = 0 has no effect. A completion and a clear in the same clock leave the event set.
- R9: A write to index 0 while a frame is running (IDLE not reached) is ignored. The register keeps its value and the running frame is not disturbed.
- R10: With speed 0, MDC stays low and writes to index 0 are ignored: no frame starts and the register keeps its value.
- R11: Reading index 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 data, 1 speed, 2 event) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |

## Verification
The bench targets the read turnaround boundary. A release one bit late would collide with the PHY's turnaround zero. A capture window off by one would shift the returned value by one bit. It runs frames at two divider settings, so a divider that counts one extra clock, or that honours bit 0, drifts out of step with the reference within a single half period. It issues an event clear in the exact clock of completion: a design that lets the clear win loses the completion. It also writes during a busy frame and with speed 0. A design that accepts either write corrupts the data register or starts a second frame on the pins.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_FRAME    = 2'd2,
        ST_FINISH   = 2'd3
    } mdio_state_e;

    localparam int FRAME_W = 32;
    localparam int DATA_W  = 16;
    localparam int OP_HI   = 29;
    localparam int OP_LO   = 28;

    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] REG_DATA  = 2'd0;
    localparam logic [1:0] REG_SPEED = 2'd1;
    localparam logic [1:0] REG_EVENT = 2'd2;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mdc,
    output logic             mdc_rise,
    output logic             mdc_fall
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             active;
    logic             tick;

    assign active   = run && (half != '0);
    assign tick     = active && (cnt_q == half - ONE);
    assign mdc_rise = tick && !mdc;
    assign mdc_fall = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] cmd,
    input  logic               mdc_rise,
    input  logic               mdc_fall,
    input  logic               mdio_i,
    output logic               busy,
    output logic               run,
    output logic               done,
    output logic               is_read,
    output logic [DATA_W-1:0]  rx_data,
    output logic               mdio_o,
    output logic               mdio_oe
);

    localparam int MAXB = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
    localparam int BC_W = $clog2(MAXB);
    localparam logic [BC_W-1:0] PRE_LAST   = BC_W'(PRE_LEN - 1);
    localparam logic [BC_W-1:0] FRAME_LAST = BC_W'(FRAME_W - 1);
    localparam logic [BC_W-1:0] REL_IDX    = BC_W'(FRAME_W - 1 - DATA_W);
    localparam logic [BC_W-1:0] CAP_IDX    = BC_W'(FRAME_W - DATA_W);
    localparam logic [BC_W-1:0] BC_ONE     = BC_W'(1);

    mdio_state_e state_q, state_d;

    logic [BC_W-1:0]    bit_cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [DATA_W-1:0]  rx_q;
    logic               rd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
                if (mdc_fall && bit_cnt_q == PRE_LAST) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (mdc_fall && bit_cnt_q == FRAME_LAST) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            rx_q      <= '0;
            rd_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q   <= cmd;
                        rd_q      <= (cmd[OP_HI:OP_LO] == OP_READ);
                        bit_cnt_q <= '0;
                        rx_q      <= '0;
                    end
                end
                ST_PREAMBLE: begin
                    if (mdc_fall) begin
                        bit_cnt_q <= (bit_cnt_q == PRE_LAST) ? '0 : bit_cnt_q + BC_ONE;
                    end
                end
                ST_FRAME: begin
                    if (mdc_rise && bit_cnt_q >= CAP_IDX) begin
                        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                    end
                    if (mdc_fall) begin
                        shreg_q   <= {shreg_q[FRAME_W-2:0], 1'b0};
                        bit_cnt_q <= bit_cnt_q + BC_ONE;
                    end
                end
                ST_FINISH: begin
                    bit_cnt_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_FRAME: begin
                mdio_o  = shreg_q[FRAME_W-1];
                mdio_oe = !(rd_q && bit_cnt_q >= REL_IDX);
            end
            ST_FINISH: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign run     = (state_q == ST_PREAMBLE) || (state_q == ST_FRAME);
    assign done    = (state_q == ST_FINISH);
    assign is_read = rd_q;
    assign rx_data = rx_q;

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int EVT_BIT = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [FRAME_W-1:0] reg_wdata,
    output logic [FRAME_W-1:0] reg_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic               is_read,
    input  logic [DATA_W-1:0]  rx_data,
    output logic               start,
    output logic [SPD_W:0]     half,
    output logic [FRAME_W-1:0] data_q,
    output logic               evt_q
);

    logic [SPD_W-1:0] spd_q;
    logic             wr_data, wr_speed, wr_event;

    assign wr_data  = reg_wr && (reg_addr == REG_DATA);
    assign wr_speed = reg_wr && (reg_addr == REG_SPEED);
    assign wr_event = reg_wr && (reg_addr == REG_EVENT);
    assign start    = wr_data && !busy && (spd_q != '0);
    assign half     = {spd_q, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (start) begin
            data_q <= reg_wdata;
        end else if (done && is_read) begin
            data_q[DATA_W-1:0] <= rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        spd_q <= '0;
        else if (wr_speed) spd_q <= reg_wdata[SPD_W:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             evt_q <= 1'b0;
        else if (done)                          evt_q <= 1'b1;
        else if (wr_event && reg_wdata[EVT_BIT]) evt_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_DATA:  reg_rdata = data_q;
            REG_SPEED: reg_rdata[SPD_W:0] = {spd_q, 1'b0};
            REG_EVENT: reg_rdata[EVT_BIT] = evt_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int SPD_W   = 6,
    parameter int EVT_BIT = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int CNT_W = SPD_W + 1;

    logic              start, busy, run, fsm_done, is_read;
    logic              mdc_rise, mdc_fall, csr_evt;
    logic [CNT_W-1:0]  half;
    logic [DATA_W-1:0] rx_data;
    logic [31:0]       csr_data;

    mdio_csr #(.SPD_W(SPD_W), .EVT_BIT(EVT_BIT)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (fsm_done),
        .is_read   (is_read),
        .rx_data   (rx_data),
        .start     (start),
        .half      (half),
        .data_q    (csr_data),
        .evt_q     (csr_evt)
    );

    mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (half),
        .mdc      (mdc),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (reg_wdata),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .run      (run),
        .done     (fsm_done),
        .is_read  (is_read),
        .rx_data  (rx_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
    import mdio_mgmt_pkg::*;
#(
    parameter int EVT_BIT = 23
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic        done,
    input logic [31:0] data_q,
    input logic        evt_q
);

    assert_mdc_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_mdio_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_evt_set_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt_q);

    assert_evt_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(done));

    assert_evt_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !done && reg_wr && reg_addr == REG_EVENT && reg_wdata[EVT_BIT]) |=> !evt_q);

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && reg_wr && reg_addr == REG_DATA) |=> (data_q == $past(data_q)));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.EVT_BIT(EVT_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .done      (fsm_done),
    .data_q    (csr_data),
    .evt_q     (csr_evt)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PRE       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit          m_active = 0;
    int          m_t = 0;
    int          m_half = 0;
    int          m_speed = 0;
    bit          m_read = 0;
    bit          m_evt = 0;
    logic [31:0] m_cmd = 0;
    logic [31:0] m_data = 0;
    logic [15:0] m_phy = 16'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    function automatic int total_len();
        return 2 * m_half * (PRE + 32);
    endfunction

    // model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_t = 0; m_speed = 0; m_evt = 0; m_data = 0;
        end else begin
            bit fin;
            fin = m_active && (m_t == total_len());
            if (m_active) begin
                if (fin) begin
                    m_active = 0;
                    m_evt = 1;
                    if (m_read) m_data[15:0] = m_phy;
                end else begin
                    m_t = m_t + 1;
                end
            end else if (reg_wr && reg_addr == 2'd0 && m_speed != 0) begin
                m_active = 1; m_t = 0; m_cmd = reg_wdata; m_data = reg_wdata;
                m_read = (reg_wdata[29:28] == 2'b10); m_half = m_speed;
            end
            if (reg_wr && reg_addr == 2'd2 && reg_wdata[23] && !fin) m_evt = 0;
            if (reg_wr && reg_addr == 2'd1) m_speed = int'(reg_wdata[6:0] & 7'h7E);
        end
    end

    // per-clock comparison of the bus pins, and PHY drive
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_mdc, e_oe, e_o;
            int b, fb;
            e_mdc = 0; e_oe = 0; e_o = 0; fb = -1;
            if (m_active && m_t < total_len()) begin
                e_mdc = ((m_t / m_half) % 2) == 1;
                b = m_t / (2 * m_half);
                if (b < PRE) begin
                    e_oe = 1; e_o = 1;
                end else begin
                    fb = b - PRE;
                    e_o = m_cmd[31-fb];
                    e_oe = !(m_read && fb >= 15);
                end
            end
            checks++;
            if (mdc !== e_mdc) begin
                failures++;
                $display("FAIL R3 mdc t=%0d act %0b exp %0b", m_t, mdc, e_mdc);
            end else if (mdio_oe !== e_oe) begin
                failures++;
                $display("FAIL R5 mdio_oe t=%0d act %0b exp %0b", m_t, mdio_oe, e_oe);
            end else if (e_oe && mdio_o !== e_o) begin
                failures++;
                $display("FAIL R2 mdio_o t=%0d act %0b exp %0b", m_t, mdio_o, e_o);
            end
            if (fb >= 16)      mdio_i = m_phy[31-fb];
            else if (fb == 15) mdio_i = 1'b0;
            else               mdio_i = 1'b1;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s reg %0d act %h exp %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] wcmd, rcmd, rcmd2;
        wcmd  = 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'h0000_BEEF;
        rcmd  = 32'h6002_0000 | (32'd5 << 23) | (32'd2 << 18);
        rcmd2 = 32'h6002_0000 | (32'd17 << 23) | (32'd31 << 18);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_reg(2'd0, 32'h0, "R1 data");
        chk_reg(2'd1, 32'h0, "R1 speed");
        chk_reg(2'd2, 32'h0, "R1 event");
        // R11 unused index
        chk_reg(2'd3, 32'h0, "R11 unused");

        // R10 speed zero: write ignored
        reg_write(2'd0, wcmd);
        repeat (8) @(negedge clk);
        chk_reg(2'd0, 32'h0, "R10 data kept");

        // R3 speed field masking
        reg_write(2'd1, 32'd7);
        chk_reg(2'd1, 32'd6, "R3 speed odd");
        reg_write(2'd1, 32'hFFFF_FFFF);
        chk_reg(2'd1, 32'h7E, "R3 speed mask");
        reg_write(2'd1, 32'd2);

        // R6 write frame
        reg_write(2'd0, wcmd);
        wait_idle();
        chk_reg(2'd0, wcmd, "R6 data unchanged");
        chk_reg(2'd2, 32'h0080_0000, "R7 event set");
        // R8 write zero ignored, then W1C
        reg_write(2'd2, 32'h0000_0000);
        chk_reg(2'd2, 32'h0080_0000, "R8 zero write");
        reg_write(2'd2, 32'h0080_0000);
        chk_reg(2'd2, 32'h0, "R8 clear");

        // R5 read frame with R9 busy write
        m_phy = 16'hA5C3;
        reg_write(2'd0, rcmd);
        repeat (20) @(negedge clk);
        reg_write(2'd0, 32'h1234_5678);
        chk_reg(2'd0, rcmd, "R9 busy write");
        chk_reg(2'd2, 32'h0, "R7 no early event");
        wait_idle();
        chk_reg(2'd0, {rcmd[31:16], 16'hA5C3}, "R5 read data");
        chk_reg(2'd2, 32'h0080_0000, "R7 event read");
        reg_write(2'd2, 32'h0080_0000);

        // second divider, clear colliding with completion (R8 set wins)
        reg_write(2'd1, 32'd6);
        m_phy = 16'h1234;
        reg_write(2'd0, rcmd2);
        while (!(m_active && m_t == total_len())) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0080_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk_reg(2'd2, 32'h0080_0000, "R8 set wins");
        chk_reg(2'd0, {rcmd2[31:16], 16'h1234}, "R5 read data h6");

        // R10 speed zero after use
        reg_write(2'd1, 32'd0);
        reg_write(2'd0, 32'hDEAD_0000);
        repeat (10) @(negedge clk);
        chk_reg(2'd0, {rcmd2[31:16], 16'h1234}, "R10 data kept");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule